// File: doc/BRIEF.md
# Multiply and Multiply-Accumulate Unit

This block multiplies two unsigned 32-bit operands into a 64-bit result and can optionally sum successive results into a 64-bit accumulator. A processor places the operands on two register outputs that feed the unit. It chooses the operating style by writing a small control word. The unit is meant to sit beside a processor register file. The transfer logic copies words between that file and the unit, and the unit exposes its state through a read selector.

There are two operating styles. In the plain multiply style, the unit samples both operands on every clock and the product follows them with one cycle of delay, while the accumulator stays at zero. In the accumulate style, nothing moves until the control word is written. Each such write samples the operands, adds their product to the accumulator, and stores the sum in both the result and the accumulator. If the 64-bit sum wraps, a sticky overflow flag is raised. Writing the control word with its flag bit set clears the flag and the accumulator before that write's own addition.

Top module: `mac_unit`

## Requirements
- R1: After reset the mode bit, the overflow flag, both captured operands, the 64-bit result and the 64-bit accumulator are all zero.
- R2: While the mode bit is 0, every clock edge stores the unsigned 64-bit product of `opa_i` and `opb_i` into the result (visible one cycle later) and forces the accumulator to zero.
- R3: A write on `cfg_wr_i` loads the mode bit from `cfg_wdata_i` bit 0 (0 selects plain multiply, 1 selects accumulate). The status word reads back with the mode at bit 0, the overflow flag at bit 1 and all other bits zero.
- R4: While the mode bit is 1, only a control write with bit 0 set samples the operands and adds their product to the accumulator, with the sum appearing on both `prod_o` and `acc_o` one cycle later. Operand changes between writes leave the result, the accumulator and the captured operands unchanged.
- R5: The overflow flag is set when an accumulation wraps past 64 bits, and it stays set through further accumulations that do not wrap.
- R6: A control write with bit 1 set clears the overflow flag and the accumulator. When the same write has bit 0 set, the addition starts from zero, so the result equals that write's product alone.
- R7: The read selector maps codes to words as follows: 0 status, 1 captured operand A, 2 captured operand B, 3 result low, 4 result high, 5 accumulator low, 6 accumulator high.
- R8: Read code 7 lies outside the register window. It raises `rd_err_o` and returns zero data.
- R9: In plain multiply mode the captured operands follow the inputs every cycle. In accumulate mode they change only on an accumulating write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opa_i | input | 32 | Operand A from the register file |
| opb_i | input | 32 | Operand B from the register file |
| cfg_wr_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word data (bit 0 mode, bit 1 clear flag) |
| rd_sel_i | input | 3 | Read word select |
| rd_data_o | output | 32 | Selected word |
| rd_err_o | output | 1 | Read select outside the window |
| prod_o | output | 64 | Result register |
| acc_o | output | 64 | Accumulator register |
| mode_o | output | 1 | Current mode bit |
| carry_o | output | 1 | Overflow flag |

## Verification
All state changes settle one clock edge after the stimulus that causes them. Both a plain-multiply operand pair and an accumulating control write are due on the edge that samples them, and the read port is combinational on top of that state. The bench drives inputs on the falling edge. It steps exactly one rising edge and then checks the outputs on the following falling edge. Checks that inputs are ignored in accumulate mode wait several edges after the operands change before reading the result, accumulator and captured operands.

// File: rtl/mac_pkg.sv
// Shared constants for the multiply-accumulate unit.
// Assumes a 3-bit read select; codes above the window are errors.
package mac_pkg;
    localparam int unsigned MODE_BIT  = 0;
    localparam int unsigned CARRY_BIT = 1;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_OPA    = 3'd1,
        SEL_OPB    = 3'd2,
        SEL_PROD_L = 3'd3,
        SEL_PROD_H = 3'd4,
        SEL_ACC_L  = 3'd5,
        SEL_ACC_H  = 3'd6,
        SEL_BAD    = 3'd7
    } rd_sel_e;

    localparam int unsigned NUM_WORDS = 7;
endpackage

// File: rtl/mac_ctrl.sv
// Control word state: mode bit and sticky overflow flag.
// Derives the per-cycle action for the datapath from the write strobe.
// Assumes ovf_i is only asserted on an accumulating cycle.
module mac_ctrl
    import mac_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         ovf_i,
    output logic         mult_en_o,
    output logic         acc_load_o,
    output logic         acc_clr_o,
    output logic         mode_o,
    output logic         carry_o
);
    logic mode_q, carry_q, mode_eff;

    // Mode in force for this cycle: a write takes effect at once.
    always_comb begin
        mode_eff   = wr_i ? wdata_i[MODE_BIT] : mode_q;
        mult_en_o  = !mode_eff;
        acc_load_o = mode_eff && wr_i;
        acc_clr_o  = wr_i && wdata_i[CARRY_BIT];
    end

    // Mode and overflow flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            if (wr_i) mode_q <= wdata_i[MODE_BIT];
            carry_q <= (acc_clr_o ? 1'b0 : carry_q) | ovf_i;
        end
    end

    assign mode_o  = mode_q;
    assign carry_o = carry_q;

    // R6: a clearing write leaves the flag low
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[CARRY_BIT]) |=> !carry_q);
    // R5: flag is sticky until cleared
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_q && !(wr_i && wdata_i[CARRY_BIT])) |=> carry_q);
    // R3: mode follows written bit 0
    p_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mode_q == $past(wdata_i[MODE_BIT])));
endmodule

// File: rtl/mac_datapath.sv
// Operand capture, unsigned multiplier, 64-bit accumulator.
// mult_en_i: sample and multiply, zero the accumulator.
// acc_load_i: sample and add product to (optionally cleared) accumulator.
// Neither: hold all state.
module mac_datapath #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic           mult_en_i,
    input  logic           acc_load_i,
    input  logic           acc_clr_i,
    output logic [W-1:0]   op0_o,
    output logic [W-1:0]   op1_o,
    output logic [2*W-1:0] prod_o,
    output logic [2*W-1:0] acc_o,
    output logic           ovf_o
);
    localparam int unsigned PW = 2 * W;

    logic [W-1:0]  op0_q, op1_q;
    logic [PW-1:0] prod_q, acc_q, mul_w, base_w, sum_w;
    logic          cout_w;

    // Product of the live inputs and the accumulation sum.
    always_comb begin
        mul_w           = PW'(opa_i) * PW'(opb_i);
        base_w          = acc_clr_i ? '0 : acc_q;
        {cout_w, sum_w} = {1'b0, base_w} + {1'b0, mul_w};
        ovf_o           = acc_load_i && cout_w;
    end

    // Operand, result and accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op0_q  <= '0;
            op1_q  <= '0;
            prod_q <= '0;
            acc_q  <= '0;
        end else if (mult_en_i) begin
            op0_q  <= opa_i;
            op1_q  <= opb_i;
            prod_q <= mul_w;
            acc_q  <= '0;
        end else if (acc_load_i) begin
            op0_q  <= opa_i;
            op1_q  <= opb_i;
            prod_q <= sum_w;
            acc_q  <= sum_w;
        end
    end

    assign op0_o  = op0_q;
    assign op1_o  = op1_q;
    assign prod_o = prod_q;
    assign acc_o  = acc_q;

    // R2: plain multiply keeps the accumulator at zero
    p_acc_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mult_en_i |=> (acc_q == '0));
    // R4: between accumulating writes everything holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mult_en_i && !acc_load_i) |=>
            ($stable(prod_q) && $stable(acc_q) && $stable(op0_q) && $stable(op1_q)));
    // R4: an accumulating write leaves result equal to accumulator
    p_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load_i |=> (prod_q == acc_q));
endmodule

// File: rtl/mac_readmux.sv
// Read-back multiplexer over the unit's words.
// Assumes the word order of rd_sel_e; codes past the window flag an error.
module mac_readmux
    import mac_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [2:0]     sel_i,
    input  logic           mode_i,
    input  logic           carry_i,
    input  logic [W-1:0]   op0_i,
    input  logic [W-1:0]   op1_i,
    input  logic [2*W-1:0] prod_i,
    input  logic [2*W-1:0] acc_i,
    output logic [W-1:0]   data_o,
    output logic           err_o
);
    logic [W-1:0] words [NUM_WORDS];
    logic [W-1:0] status_w;

    // Status word: mode and flag at fixed bits, rest zero.
    always_comb begin
        status_w            = '0;
        status_w[MODE_BIT]  = mode_i;
        status_w[CARRY_BIT] = carry_i;
    end

    assign words[SEL_STATUS] = status_w;
    assign words[SEL_OPA]    = op0_i;
    assign words[SEL_OPB]    = op1_i;

    // Split the two wide registers into halves.
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign words[int'(SEL_PROD_L) + h] = prod_i[h*W +: W];
        assign words[int'(SEL_ACC_L) + h]  = acc_i[h*W +: W];
    end

    // Select a word or flag an out-of-window code.
    always_comb begin
        if (32'(sel_i) < NUM_WORDS) begin
            data_o = words[sel_i];
            err_o  = 1'b0;
        end else begin
            data_o = '0;
            err_o  = 1'b1;
        end
    end
endmodule

// File: rtl/mac_unit.sv
// Multiply / multiply-accumulate unit top level.
// Wires control, datapath and read-back; no logic of its own.
module mac_unit #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic           cfg_wr_i,
    input  logic [W-1:0]   cfg_wdata_i,
    input  logic [2:0]     rd_sel_i,
    output logic [W-1:0]   rd_data_o,
    output logic           rd_err_o,
    output logic [2*W-1:0] prod_o,
    output logic [2*W-1:0] acc_o,
    output logic           mode_o,
    output logic           carry_o
);
    logic         mult_en, acc_load, acc_clr, ovf;
    logic [W-1:0] op0, op1;

    mac_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
        .ovf_i(ovf), .mult_en_o(mult_en), .acc_load_o(acc_load),
        .acc_clr_o(acc_clr), .mode_o(mode_o), .carry_o(carry_o)
    );

    mac_datapath #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .opa_i(opa_i), .opb_i(opb_i),
        .mult_en_i(mult_en), .acc_load_i(acc_load), .acc_clr_i(acc_clr),
        .op0_o(op0), .op1_o(op1), .prod_o(prod_o), .acc_o(acc_o), .ovf_o(ovf)
    );

    mac_readmux #(.W(W)) u_rd (
        .sel_i(rd_sel_i), .mode_i(mode_o), .carry_i(carry_o),
        .op0_i(op0), .op1_i(op1), .prod_i(prod_o), .acc_i(acc_o),
        .data_o(rd_data_o), .err_o(rd_err_o)
    );

    // R8: out-of-window read returns zero data
    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_o |-> (rd_data_o == '0));
    // R1: first cycle after reset shows cleared state
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (prod_o == '0 && acc_o == '0 && !mode_o && !carry_o));
endmodule

// File: tb/mac_unit_test.sv
module mac_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0, opb = '0, wdata = '0;
    logic        wr = 1'b0;
    logic [2:0]  sel = '0;
    logic [31:0] rd_data;
    logic        rd_err, mode, carry;
    logic [63:0] prod, acc;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    mac_unit uut (
        .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb),
        .cfg_wr_i(wr), .cfg_wdata_i(wdata), .rd_sel_i(sel),
        .rd_data_o(rd_data), .rd_err_o(rd_err), .prod_o(prod), .acc_o(acc),
        .mode_o(mode), .carry_o(carry)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        sel = s;
        #1;
        d = rd_data;
    endtask

    task automatic cfg_write(input logic [31:0] d, input logic [31:0] a, input logic [31:0] b);
        opa = a; opb = b; wdata = d; wr = 1'b1;
        step();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 prod", prod, 64'd0);
        chk("R1 acc", acc, 64'd0);
        rd(3'd0, d); chk("R1 status", 64'(d), 64'd0);
        rd(3'd1, d); chk("R1 opa", 64'(d), 64'd0);
    endtask

    task automatic t_mult(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] d;
        opa = a; opb = b;
        step();
        chk("R2 prod", prod, 64'(a) * 64'(b));
        chk("R2 acc zero", acc, 64'd0);
        rd(3'd1, d); chk("R9 opa follows", 64'(d), 64'(a));
        rd(3'd2, d); chk("R9 opb follows", 64'(d), 64'(b));
    endtask

    task automatic t_mac();
        logic [31:0] d;
        cfg_write(32'h1, 32'd3, 32'd5);
        chk("R4 first sum", prod, 64'd15);
        chk("R4 acc", acc, 64'd15);
        rd(3'd0, d); chk("R3 status mac", 64'(d), 64'd1);
        opa = 32'd100; opb = 32'd100;
        repeat (3) step();
        chk("R4 ignored prod", prod, 64'd15);
        chk("R4 ignored acc", acc, 64'd15);
        rd(3'd1, d); chk("R9 opa held", 64'(d), 64'd3);
        cfg_write(32'h1, 32'd2, 32'd7);
        chk("R4 second sum", acc, 64'd29);
        chk("R4 prod eq acc", prod, 64'd29);
    endtask

    task automatic t_carry();
        logic [31:0] d;
        logic [63:0] p;
        p = 64'hFFFF_FFFE_0000_0001;
        cfg_write(32'h3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R6 clear then product", acc, p);
        chk("R6 flag low", 64'(carry), 64'd0);
        cfg_write(32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R5 wrapped sum", acc, p + p);
        chk("R5 flag set", 64'(carry), 64'd1);
        rd(3'd0, d); chk("R3 status bits", 64'(d), 64'd3);
        cfg_write(32'h1, 32'd0, 32'd0);
        chk("R5 flag sticky", 64'(carry), 64'd1);
        chk("R5 acc unchanged", acc, p + p);
        cfg_write(32'h3, 32'd1, 32'd1);
        chk("R6 acc restart", acc, 64'd1);
        chk("R6 flag cleared", 64'(carry), 64'd0);
    endtask

    task automatic t_readmap();
        logic [31:0] d;
        cfg_write(32'h3, 32'hDEAD_0001, 32'h0000_1000);
        p_chk_map(64'(32'hDEAD_0001) * 64'(32'h1000));
        rd(3'd7, d);
        chk("R8 err flag", 64'(rd_err), 64'd1);
        chk("R8 zero data", 64'(d), 64'd0);
        rd(3'd4, d);
        chk("R8 no err in window", 64'(rd_err), 64'd0);
    endtask

    task automatic p_chk_map(input logic [63:0] v);
        logic [31:0] d;
        rd(3'd1, d); chk("R7 code1", 64'(d), 64'(32'hDEAD_0001));
        rd(3'd2, d); chk("R7 code2", 64'(d), 64'(32'h0000_1000));
        rd(3'd3, d); chk("R7 code3", 64'(d), 64'(v[31:0]));
        rd(3'd4, d); chk("R7 code4", 64'(d), 64'(v[63:32]));
        rd(3'd5, d); chk("R7 code5", 64'(d), 64'(v[31:0]));
        rd(3'd6, d); chk("R7 code6", 64'(d), 64'(v[63:32]));
    endtask

    task automatic t_back_to_mult();
        logic [31:0] d;
        cfg_write(32'h0, 32'd6, 32'd9);
        chk("R2 mode switch prod", prod, 64'd54);
        chk("R2 mode switch acc", acc, 64'd0);
        rd(3'd0, d); chk("R3 status mult", 64'(d), 64'd0);
        t_mult(32'd11, 32'd13);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_mult(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_mult(32'h1234_5678, 32'h9ABC_DEF0);
        t_mult(32'd0, 32'h7777_7777);
        t_mac();
        t_carry();
        t_readmap();
        t_back_to_mult();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule